// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits on the device side of a four-bank, 16-bit single-data-rate SDRAM interface. At every rising clock edge it samples the active-low chip select, row strobe, column strobe and write enable. It turns them into one of six commands: open a row, close a bank, read, write, load the mode register, or do nothing. It records which banks hold an open row and which row each one holds. For column accesses it captures the column address and the auto-close flag. It also stores the mode opcode.

A clock-enable input suspends the block. When clock enable is sampled low at an edge, that edge still takes effect. Every later edge is ignored until an edge has sampled clock enable high again. If clock enable drops while all banks are idle, the block reports power-down. Misuse of banks raises a one-cycle error pulse, and the bank state is left as it was.

All outputs are registered. A command sampled at edge N shows on the outputs during the cycle that follows edge N.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: When `cs_n` is sampled high, the edge raises no strobe and no error pulse, and it changes no bank, selection or mode state.
- R2: With `cs_n` low, {`ras_n`,`cas_n`,`we_n`} decodes as follows: 011 is open-row, 010 is close, 101 is read, 100 is write and 000 is mode load. Codes 001, 110 and 111 are no-ops. The matching strobe is high for exactly the one cycle after the sampling edge. At most one of the five strobes and `illegal` is high in any cycle.
- R3: Open-row on an idle bank sets `bank_active[ba]`, stores `addr` as that bank's row, and updates `sel_bank` to `ba` and `sel_row` to `addr`.
- R4: A close command returns bank `ba` to idle and sets `sel_bank` to `ba`. If `addr[10]` is 1, all four banks become idle whatever `ba` holds. Closing an idle bank is legal.
- R5: A read or write to an active bank sets `sel_col` to `addr[8:0]` and `auto_close` to `addr[10]`, and sets `sel_row` to that bank's open row. When `addr[10]` is 1, the bank becomes idle at the same edge.
- R6: Bank bits 0, 1, 2 and 3 select banks A to D. Bank i is reported as `bank_active[i]`, and its open row is reported as `open_rows[i*12 +: 12]`.
- R7: A read or write to an idle bank, or an open-row to an active bank, raises `illegal` for one cycle. It raises no command strobe and changes no bank or selection state.
- R8: A mode load copies `addr` into `mode_q`.
- R9: An edge that samples `cke` low is still processed. Each following edge is frozen until the edge after one that samples `cke` high. A frozen edge holds all state and raises no strobe or error pulse.
- R10: `pwr_down` rises after a processed edge that samples `cke` low and leaves all banks idle. It stays high while `cke` is low and clears after the first edge that samples `cke` high. While `pwr_down` is high, no bank is active.
- R11: After a synchronous active-low reset, all banks are idle and all rows, selections and `mode_q` are zero. No strobe, `illegal` or `pwr_down` is asserted, and the block is not frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable; low suspends later edges |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Row address, column address, auto-close/close-all flag, or mode opcode |
| act_stb | output | 1 | Open-row command accepted |
| pre_stb | output | 1 | Close command accepted |
| rd_stb | output | 1 | Read accepted |
| wr_stb | output | 1 | Write accepted |
| mrs_stb | output | 1 | Mode load accepted |
| illegal | output | 1 | One-cycle bank misuse pulse |
| bank_active | output | 4 | Per-bank open flag |
| open_rows | output | 48 | Open row of each bank, 12 bits per bank |
| sel_bank | output | 2 | Bank of the last accepted bank command |
| sel_row | output | 12 | Row of the last accepted open or column access |
| sel_col | output | 9 | Column of the last accepted access |
| auto_close | output | 1 | Auto-close flag of the last accepted access |
| mode_q | output | 12 | Stored mode opcode |
| pwr_down | output | 1 | Power-down state |

## Verification
Two functions can fall on the same edge. A command can arrive on the very edge where clock enable drops, and a close-all can coincide with power-down entry. The bench provokes both by driving clock enable low together with an open-row, and then together with a close-all while banks are open. A reference model computes the result of each edge on its own. The bench then confirms that the command took effect and that the next edge was frozen. It also confirms that `pwr_down` rises only when that same edge leaves every bank idle. The full sweep crosses all 16 strobe patterns with every bank and both values of the address flag, so it reaches every legal and illegal bank transition.

// File: rtl/sdr_pkg.sv
// Shared types for the SDRAM command tracker.
package sdr_pkg;
    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_PRE,
        CMD_RD,
        CMD_WR,
        CMD_MRS
    } sdr_cmd_e;
endpackage

// File: rtl/sdr_cmd_decode.sv
// Combinational strobe decoder.
// Assumes all strobes are active low and already sampled on the clock.
// Refresh, burst stop and the idle pattern all collapse to NOP.
module sdr_cmd_decode
    import sdr_pkg::*;
(
    input  logic     cs_n,
    input  logic     ras_n,
    input  logic     cas_n,
    input  logic     we_n,
    output sdr_cmd_e cmd
);
    // Map the strobe pattern onto a command.
    always_comb begin
        cmd = CMD_NOP;
        if (!cs_n) begin
            case ({ras_n, cas_n, we_n})
                3'b011:  cmd = CMD_ACT;
                3'b010:  cmd = CMD_PRE;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b000:  cmd = CMD_MRS;
                default: cmd = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/sdr_bank_slot.sv
// State of one bank: the open flag and the open row.
// Assumes open and close are never asserted together for the same slot.
module sdr_bank_slot #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              open_i,
    input  logic              close_i,
    input  logic [ADDR_W-1:0] row_i,
    output logic              active_o,
    output logic [ADDR_W-1:0] row_o
);
    // Open the bank with a new row, or close it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            row_o    <= '0;
        end else if (open_i) begin
            active_o <= 1'b1;
            row_o    <= row_i;
        end else if (close_i) begin
            active_o <= 1'b0;
        end
    end
endmodule

// File: rtl/sdr_pd_ctrl.sv
// Clock-enable suspend and power-down tracking.
// en_o is high when the current edge may act, which is when the previous edge
// sampled cke high. Power-down is entered only at a processed edge that leaves
// every bank idle.
module sdr_pd_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    input  logic idle_next,
    output logic en_o,
    output logic pd_o
);
    // Remember the last cke sample and track power-down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o <= 1'b1;
            pd_o <= 1'b0;
        end else begin
            en_o <= cke;
            if (cke)
                pd_o <= 1'b0;
            else if (en_o && idle_next)
                pd_o <= 1'b1;
        end
    end
endmodule

// File: rtl/sdram_cmd_tracker.sv
// Device-side SDRAM command decoder and bank tracker.
// Decodes the strobes sampled at each edge and keeps the per-bank open rows.
// Captures column access details and the mode opcode.
// Assumes NUM_BANKS is a power of two and AP_BIT < ADDR_W.
module sdram_cmd_tracker
    import sdr_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 12,
    parameter int COL_W     = 9,
    parameter int AP_BIT    = 10,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cke,
    input  logic                        cs_n,
    input  logic                        ras_n,
    input  logic                        cas_n,
    input  logic                        we_n,
    input  logic [BA_W-1:0]             ba,
    input  logic [ADDR_W-1:0]           addr,
    output logic                        act_stb,
    output logic                        pre_stb,
    output logic                        rd_stb,
    output logic                        wr_stb,
    output logic                        mrs_stb,
    output logic                        illegal,
    output logic [NUM_BANKS-1:0]        bank_active,
    output logic [NUM_BANKS*ADDR_W-1:0] open_rows,
    output logic [BA_W-1:0]             sel_bank,
    output logic [ADDR_W-1:0]           sel_row,
    output logic [COL_W-1:0]            sel_col,
    output logic                        auto_close,
    output logic [ADDR_W-1:0]           mode_q,
    output logic                        pwr_down
);
    sdr_cmd_e             cmd;
    logic                 en;
    logic                 tgt_active;
    logic                 is_col;
    logic                 bad;
    logic                 flag;
    logic [NUM_BANKS-1:0] open_v;
    logic [NUM_BANKS-1:0] close_v;
    logic [NUM_BANKS-1:0] next_active;
    logic [ADDR_W-1:0]    tgt_row;

    sdr_cmd_decode u_dec (
        .cs_n (cs_n),
        .ras_n(ras_n),
        .cas_n(cas_n),
        .we_n (we_n),
        .cmd  (cmd)
    );

    // Check the target bank and work out the per-bank open and close requests.
    always_comb begin
        tgt_active = bank_active[ba];
        tgt_row    = open_rows[ba*ADDR_W +: ADDR_W];
        flag       = addr[AP_BIT];
        is_col     = (cmd == CMD_RD) || (cmd == CMD_WR);
        bad        = (is_col && !tgt_active) || (cmd == CMD_ACT && tgt_active);
        for (int i = 0; i < NUM_BANKS; i++) begin
            open_v[i]  = en && cmd == CMD_ACT && !tgt_active && ba == BA_W'(i);
            close_v[i] = en && ((cmd == CMD_PRE && (flag || ba == BA_W'(i))) ||
                                (is_col && tgt_active && flag && ba == BA_W'(i)));
        end
        next_active = (bank_active & ~close_v) | open_v;
    end

    generate
        for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
            sdr_bank_slot #(.ADDR_W(ADDR_W)) u_slot (
                .clk     (clk),
                .rst_n   (rst_n),
                .open_i  (open_v[g]),
                .close_i (close_v[g]),
                .row_i   (addr),
                .active_o(bank_active[g]),
                .row_o   (open_rows[g*ADDR_W +: ADDR_W])
            );
        end
    endgenerate

    sdr_pd_ctrl u_pd (
        .clk      (clk),
        .rst_n    (rst_n),
        .cke      (cke),
        .idle_next(~|next_active),
        .en_o     (en),
        .pd_o     (pwr_down)
    );

    // One-cycle strobes for accepted commands and for misuse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_stb <= 1'b0;
            pre_stb <= 1'b0;
            rd_stb  <= 1'b0;
            wr_stb  <= 1'b0;
            mrs_stb <= 1'b0;
            illegal <= 1'b0;
        end else begin
            act_stb <= en && cmd == CMD_ACT && !bad;
            pre_stb <= en && cmd == CMD_PRE;
            rd_stb  <= en && cmd == CMD_RD && !bad;
            wr_stb  <= en && cmd == CMD_WR && !bad;
            mrs_stb <= en && cmd == CMD_MRS;
            illegal <= en && bad;
        end
    end

    // Selection registers and the mode opcode, held on frozen edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_bank   <= '0;
            sel_row    <= '0;
            sel_col    <= '0;
            auto_close <= 1'b0;
            mode_q     <= '0;
        end else if (en && !bad) begin
            case (cmd)
                CMD_ACT: begin
                    sel_bank <= ba;
                    sel_row  <= addr;
                end
                CMD_PRE: sel_bank <= ba;
                CMD_RD, CMD_WR: begin
                    sel_bank   <= ba;
                    sel_row    <= tgt_row;
                    sel_col    <= addr[COL_W-1:0];
                    auto_close <= flag;
                end
                CMD_MRS: mode_q <= addr;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
// Property checker for the SDRAM command tracker, attached by bind.
module sdram_cmd_tracker_chk #(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 12,
    parameter int BA_W      = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cke,
    input logic                 cs_n,
    input logic                 act_stb,
    input logic                 pre_stb,
    input logic                 rd_stb,
    input logic                 wr_stb,
    input logic                 mrs_stb,
    input logic                 illegal,
    input logic [NUM_BANKS-1:0] bank_active,
    input logic [BA_W-1:0]      sel_bank,
    input logic [ADDR_W-1:0]    mode_q,
    input logic                 pwr_down
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({act_stb, pre_stb, rd_stb, wr_stb, mrs_stb, illegal})); // R2
    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> !(act_stb || pre_stb || rd_stb || wr_stb || mrs_stb || illegal)); // R1
    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        act_stb |-> bank_active[sel_bank]); // R3
    AST_ILLEGAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> $stable(bank_active)); // R7
    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cke) |=> ($stable(bank_active) && $stable(mode_q))); // R9
    AST_PD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |-> (bank_active == '0)); // R10
endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .BA_W(BA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n),
    .act_stb(act_stb), .pre_stb(pre_stb), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .mrs_stb(mrs_stb), .illegal(illegal), .bank_active(bank_active),
    .sel_bank(sel_bank), .mode_q(mode_q), .pwr_down(pwr_down)
);

// File: tb/tb_sdram_cmd_tracker.sv
// Sweep bench with a reference model of the tracker.
module tb_sdram_cmd_tracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0]  ba = '0;
    logic [11:0] addr = '0;
    logic        act_stb, pre_stb, rd_stb, wr_stb, mrs_stb, illegal, auto_close, pwr_down;
    logic [3:0]  bank_active;
    logic [47:0] open_rows;
    logic [1:0]  sel_bank;
    logic [11:0] sel_row, mode_q;
    logic [8:0]  sel_col;

    int checks = 0;
    int fails  = 0;

    // Model state.
    logic        m_en = 1'b1, m_pd = 1'b0, m_ac = 1'b0;
    logic [3:0]  m_act = '0;
    logic [11:0] m_row [4];
    logic [1:0]  m_sb = '0;
    logic [11:0] m_sr = '0, m_mode = '0;
    logic [8:0]  m_sc = '0;
    logic [5:0]  m_stb = '0;  // {act,pre,rd,wr,mrs,illegal}

    always #2.5 clk = ~clk;

    sdram_cmd_tracker dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .act_stb(act_stb), .pre_stb(pre_stb), .rd_stb(rd_stb), .wr_stb(wr_stb),
        .mrs_stb(mrs_stb), .illegal(illegal), .bank_active(bank_active),
        .open_rows(open_rows), .sel_bank(sel_bank), .sel_row(sel_row),
        .sel_col(sel_col), .auto_close(auto_close), .mode_q(mode_q),
        .pwr_down(pwr_down)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every output against the model.
    task automatic compare_all(input string tag);
        chk({tag, " R2 strobes"}, 64'({act_stb, pre_stb, rd_stb, wr_stb, mrs_stb, illegal}), 64'(m_stb));
        chk({tag, " R6 bank_active"}, 64'(bank_active), 64'(m_act));
        for (int i = 0; i < 4; i++)
            chk({tag, " R6 open_rows"}, 64'(open_rows[i*12 +: 12]), 64'(m_row[i]));
        chk({tag, " R3 sel_bank"}, 64'(sel_bank), 64'(m_sb));
        chk({tag, " R5 sel_row"}, 64'(sel_row), 64'(m_sr));
        chk({tag, " R5 sel_col"}, 64'(sel_col), 64'(m_sc));
        chk({tag, " R5 auto_close"}, 64'(auto_close), 64'(m_ac));
        chk({tag, " R8 mode_q"}, 64'(mode_q), 64'(m_mode));
        chk({tag, " R10 pwr_down"}, 64'(pwr_down), 64'(m_pd));
    endtask

    // Drive one cycle at a falling edge, advance the model, and sample at the next falling edge.
    task automatic step(input logic k, input logic [3:0] code, input logic [1:0] b,
                        input logic [11:0] a, input string tag);
        logic [2:0] op;
        logic       f, col, bad;
        logic [3:0] nxt;
        cke = k; cs_n = code[3]; ras_n = code[2]; cas_n = code[1]; we_n = code[0];
        ba = b; addr = a;
        op  = code[3] ? 3'b111 : code[2:0];
        f   = a[10];
        col = (op == 3'b101) || (op == 3'b100);
        bad = (col && !m_act[b]) || (op == 3'b011 && m_act[b]);
        m_stb = '0;
        if (m_en) begin
            if (bad) m_stb[0] = 1'b1;
            else case (op)
                3'b011: begin m_act[b] = 1'b1; m_row[b] = a; m_sb = b; m_sr = a; m_stb[5] = 1'b1; end
                3'b010: begin
                    if (f) m_act = '0; else m_act[b] = 1'b0;
                    m_sb = b; m_stb[4] = 1'b1;
                end
                3'b101, 3'b100: begin
                    m_sb = b; m_sr = m_row[b]; m_sc = a[8:0]; m_ac = f;
                    if (f) m_act[b] = 1'b0;
                    if (op == 3'b101) m_stb[3] = 1'b1; else m_stb[2] = 1'b1;
                end
                3'b000: begin m_mode = a; m_stb[1] = 1'b1; end
                default: ;
            endcase
        end
        nxt = m_act;
        if (k) m_pd = 1'b0;
        else if (m_en && nxt == '0) m_pd = 1'b1;
        m_en = k;
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) m_row[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R11 reset");
        // Sweep A: strobe pattern outermost.
        for (int c = 0; c < 16; c++)
            for (int b = 0; b < 4; b++)
                for (int f = 0; f < 2; f++)
                    step(1'b1, 4'(c), 2'(b), 12'((c * 149 + b * 37 + 5) & 12'hBFF) | 12'(f << 10), "sweepA R1 R4 R7");
        // Sweep B: bank outermost, so column accesses find open banks.
        for (int b = 0; b < 4; b++)
            for (int f = 0; f < 2; f++)
                for (int c = 0; c < 16; c++)
                    step(1'b1, 4'(c), 2'(b), 12'((c * 83 + b * 211 + 9) & 12'hBFF) | 12'(f << 10), "sweepB R3 R5 R8");
        // A command on the edge where cke drops still executes; later edges are frozen.
        step(1'b1, 4'b0010, 2'd0, 12'h400, "R4 close all");
        step(1'b0, 4'b0011, 2'd1, 12'h123, "R9 act with cke drop");
        step(1'b0, 4'b0010, 2'd0, 12'h400, "R9 frozen close");
        step(1'b1, 4'b0101, 2'd1, 12'h011, "R9 still frozen");
        step(1'b1, 4'b0101, 2'd1, 12'h022, "R9 resumed read");
        step(1'b1, 4'b0011, 2'd2, 12'h3A5, "R3 act bank C");
        // A close-all on the edge where cke drops enters power-down.
        step(1'b0, 4'b0010, 2'd3, 12'h400, "R10 close all with cke low");
        step(1'b0, 4'b0011, 2'd0, 12'h055, "R10 hold in power-down");
        step(1'b1, 4'b0111, 2'd0, 12'h000, "R10 exit");
        step(1'b1, 4'b0011, 2'd0, 12'h0AA, "R3 act bank A");
        step(1'b0, 4'b0111, 2'd0, 12'h000, "R10 no entry while active");
        step(1'b1, 4'b0111, 2'd0, 12'h000, "R9 frozen nop");
        step(1'b1, 4'b1000, 2'd0, 12'h7FF, "R1 deselect");
        step(1'b1, 4'b0000, 2'd0, 12'h5A5, "R8 mode load");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule